// File: doc/BRIEF.md
# Bit matrix row and diagonal reader

This block holds a square bit matrix of 16 rows by 16 bits. Each bit position (column) has its own 16-deep, one-bit-wide memory with its own read index. A single write port can either overwrite one whole row in one clock edge, or push a new row in at row 0 so that every column moves down by one entry at once.

The read port returns 16 bits per access and has two modes. In row mode it returns one stored row. In diagonal mode it returns a cyclic diagonal: bit `i` comes from column `i` at row `(address + i) mod 16`, so the diagonal wraps back to row 0 when it passes row 15. Because each column is indexed on its own, both kinds of access take the same single cycle.

The column memories are read combinationally from their per-column index. The read data then passes through an output register, which can be removed by a parameter. With the default settings, a read shows at `rd_data` one clock after the address and mode are sampled. The matrix contents are not cleared by reset, so the user loads the matrix before reading it.

Top module: `bitmat_reader`

## Requirements
- R1: While `rst_n` is low, `rd_data` is 0, and it stays 0 until the first clock edge after reset is released.
- R2: With `wr_en`=1 and `wr_op`=0, one clock edge stores `wr_data` as row `wr_row`. Bit `i` of `wr_data` goes to column `i`, and the other rows keep their contents.
- R3: With `wr_en`=1 and `wr_op`=1, every row `r` from 1 to 15 takes the old contents of row `r-1`, row 0 takes `wr_data`, and the old row 15 is lost.
- R4: With `rd_mode`=0, `rd_data` bit `i` equals bit `i` of the row selected by `rd_addr`.
- R5: With `rd_mode`=1, `rd_data` bit `i` equals column `i` of row `(rd_addr + i) mod 16`.
- R6: With the output register enabled (the default), `rd_data` reflects the `rd_mode` and `rd_addr` sampled at the previous clock edge. Back-to-back reads at different addresses and modes each give their own result.
- R7: When a write and a read touch the same location at the same edge, the read returns the contents from before that write. The new contents show on the next read.
- R8: With `wr_en`=0, the values on `wr_op`, `wr_row` and `wr_data` leave every stored bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all writes and the output register act on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the output register only |
| wr_en | input | 1 | Write strobe |
| wr_op | input | 1 | Write kind: 0 overwrites one row, 1 shifts a new row in at row 0 |
| wr_row | input | 4 | Row written by a row write |
| wr_data | input | 16 | Write data, bit i for column i |
| rd_mode | input | 1 | Read kind: 0 row, 1 wrapped diagonal |
| rd_addr | input | 4 | Row index for a row read; starting row for a diagonal |
| rd_data | output | 16 | Read result, bit i from column i |

## Verification
A fault in one column memory shows only in that bit position of `rd_data`. A row read exposes it at one address. A diagonal read exposes it at a different starting address for each column, so the bench sweeps every address in both modes. A wrong per-column index shows up in diagonal mode only, and it shows up on the first read after the address is sampled: one cycle with the output register. A shift that misaligns the columns corrupts every row below the point where the columns diverge, so it is visible at the very next full readback.

// File: rtl/bitmat_pkg.sv
package bitmat_pkg;

    typedef enum logic {
        RD_ROW  = 1'b0,
        RD_DIAG = 1'b1
    } rd_mode_e;

    typedef enum logic {
        WR_ROW   = 1'b0,
        WR_SHIFT = 1'b1
    } wr_op_e;

endpackage

// File: rtl/bitmat_column.sv
module bitmat_column
    import bitmat_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  wr_op_e        wr_op,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_bit,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_bit
);

    // Entry k of this column is bit k of the vector.
    logic [DEPTH-1:0] cells;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            unique case (wr_op)
                WR_ROW:   cells[wr_addr] <= wr_bit;
                WR_SHIFT: cells <= {cells[DEPTH-2:0], wr_bit};
                default:  cells <= cells;
            endcase
        end
    end

    // Combinational read, like a small distributed memory.
    assign rd_bit = cells[rd_addr];

endmodule

// File: rtl/bitmat_rowsel.sv
module bitmat_rowsel
    import bitmat_pkg::*;
#(
    parameter int N   = 16,
    localparam int AW = $clog2(N),
    localparam int SW = AW + 1
) (
    input  rd_mode_e              rd_mode,
    input  logic [AW-1:0]         rd_addr,
    output logic [N-1:0][AW-1:0]  col_addr
);

    for (genvar c = 0; c < N; c++) begin : g_idx
        logic [SW-1:0] sum;
        logic [AW-1:0] wrapped;

        assign sum     = {1'b0, rd_addr} + SW'(c);
        assign wrapped = (sum >= SW'(N)) ? AW'(sum - SW'(N)) : AW'(sum);

        always_comb begin
            unique case (rd_mode)
                RD_ROW:  col_addr[c] = rd_addr;
                RD_DIAG: col_addr[c] = wrapped;
                default: col_addr[c] = rd_addr;
            endcase
        end
    end

endmodule

// File: rtl/bitmat_outreg.sv
module bitmat_outreg #(
    parameter int W   = 16,
    parameter bit REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    if (REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else begin
                q <= d;
            end
        end
    end else begin : g_pass
        assign q = d;
    end

endmodule

// File: rtl/bitmat_reader.sv
module bitmat_reader
    import bitmat_pkg::*;
#(
    parameter int N       = 16,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_op,
    input  logic [$clog2(N)-1:0] wr_row,
    input  logic [N-1:0]         wr_data,
    input  logic                 rd_mode,
    input  logic [$clog2(N)-1:0] rd_addr,
    output logic [N-1:0]         rd_data
);

    localparam int AW = $clog2(N);

    logic [N-1:0][AW-1:0] col_addr;
    logic [N-1:0]         col_bits;

    bitmat_rowsel #(.N(N)) u_sel (
        .rd_mode (rd_mode_e'(rd_mode)),
        .rd_addr (rd_addr),
        .col_addr(col_addr)
    );

    for (genvar c = 0; c < N; c++) begin : g_col
        bitmat_column #(.DEPTH(N)) u_col (
            .clk    (clk),
            .wr_en  (wr_en),
            .wr_op  (wr_op_e'(wr_op)),
            .wr_addr(wr_row),
            .wr_bit (wr_data[c]),
            .rd_addr(col_addr[c]),
            .rd_bit (col_bits[c])
        );
    end

    bitmat_outreg #(.W(N), .REG(OUT_REG)) u_out (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (col_bits),
        .q    (rd_data)
    );

endmodule

// File: rtl/bitmat_reader_chk.sv
module bitmat_reader_chk #(
    parameter int N       = 16,
    parameter bit OUT_REG = 1'b1,
    localparam int AW     = $clog2(N)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic                 wr_op,
    input logic [AW-1:0]        wr_row,
    input logic [N-1:0]         wr_data,
    input logic                 rd_mode,
    input logic [AW-1:0]        rd_addr,
    input logic [N-1:0]         rd_data,
    input logic [N-1:0][AW-1:0] col_addr
);

    logic [1:0] live;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live <= 2'd0;
        end else if (live != 2'd3) begin
            live <= live + 2'd1;
        end
    end

    // R4
    for (genvar c = 0; c < N; c++) begin : g_row_idx
        row_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_mode |-> col_addr[c] == rd_addr);
    end

    // R5
    diag_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_mode |-> col_addr[0] == rd_addr);

    // R5
    for (genvar c = 0; c < N; c++) begin : g_diag_step
        diag_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_mode |-> col_addr[(c + 1) % N] == AW'((int'(col_addr[c]) + 1) % N));
    end

    if (OUT_REG) begin : g_reg_chk
        // R1
        rst_clears_chk: assert property (@(posedge clk)
            !rst_n |=> rd_data == '0);

        // R2
        row_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(wr_en) && !$past(wr_op) && !rd_mode && rd_addr == $past(wr_row))
            |=> rd_data == $past(wr_data, 2));

        // R3
        shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(wr_en) && $past(wr_op) && !rd_mode && rd_addr == '0)
            |=> rd_data == $past(wr_data, 2));

        // R8
        hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (live >= 2'd2 && !$past(wr_en) && $stable(rd_addr) && $stable(rd_mode))
            |=> $stable(rd_data));
    end

endmodule

bind bitmat_reader bitmat_reader_chk #(.N(N), .OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/bitmat_reader_tb.sv
module bitmat_reader_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_op = 1'b0;
    logic [3:0]  wr_row = '0;
    logic [15:0] wr_data = '0;
    logic        rd_mode = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    string cur_tag = "R1";
    string tag_q = "R1";

    logic [15:0] m [N];
    bit          v [N];
    logic [15:0] exp_q = '0;
    bit          exp_v = 0;

    bitmat_reader u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_op  (wr_op),
        .wr_row (wr_row),
        .wr_data(wr_data),
        .rd_mode(rd_mode),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial begin
        for (int r = 0; r < N; r++) begin
            v[r] = 0;
            m[r] = '0;
        end
    end

    // Behavioural reference: result of each edge, then memory update.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_q <= '0;
            exp_v <= 1;
            tag_q <= "R1";
        end else begin
            logic [15:0] e;
            bit ok;
            ok = 1;
            if (rd_mode == 1'b0) begin
                e  = m[rd_addr];
                ok = v[rd_addr];
            end else begin
                for (int i = 0; i < N; i++) begin
                    int r;
                    r = (int'(rd_addr) + i) % N;
                    e[i] = m[r][i];
                    ok = ok && v[r];
                end
            end
            exp_q <= e;
            exp_v <= ok;
            tag_q <= cur_tag;
            if (wr_en) begin
                if (wr_op == 1'b0) begin
                    m[wr_row] = wr_data;
                    v[wr_row] = 1;
                end else begin
                    for (int r = N - 1; r > 0; r--) begin
                        m[r] = m[r - 1];
                        v[r] = v[r - 1];
                    end
                    m[0] = wr_data;
                    v[0] = 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (exp_v && !done) begin
            checks++;
            if (rd_data !== exp_q) begin
                errors++;
                $display("FAIL %s rd_data=%h expected=%h", tag_q, rd_data, exp_q);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 20000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL R6 watchdog expired rd_data=%h expected=%h", rd_data, exp_q);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic cyc(input logic we, input logic op, input logic [3:0] row,
                       input logic [15:0] data, input logic mode, input logic [3:0] addr);
        @(negedge clk);
        wr_en   = we;
        wr_op   = op;
        wr_row  = row;
        wr_data = data;
        rd_mode = mode;
        rd_addr = addr;
    endtask

    function automatic logic [15:0] pat(input int r);
        return ({4{4'(r)}} ^ 16'hA5C3) + 16'(r * 37);
    endfunction

    initial begin
        // R1: reset holds output at zero
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: load every row, reading the row being written (old, unknown)
        cur_tag = "R2";
        for (int r = 0; r < N; r++) cyc(1'b1, 1'b0, 4'(r), pat(r), 1'b0, 4'(r));
        for (int r = 0; r < N; r++) cyc(1'b0, 1'b0, 4'd0, 16'h0, 1'b0, 4'(r));

        // R4: row reads in scattered order
        cur_tag = "R4";
        for (int r = 0; r < N; r++) cyc(1'b0, 1'b0, 4'd0, 16'h0, 1'b0, 4'((r * 7) % N));

        // R5: every wrapped diagonal
        cur_tag = "R5";
        for (int a = 0; a < N; a++) cyc(1'b0, 1'b0, 4'd0, 16'h0, 1'b1, 4'(a));

        // R8: write controls toggling with wr_en low, then full readback
        cur_tag = "R8";
        for (int k = 0; k < 8; k++)
            cyc(1'b0, 1'(k), 4'((k * 3) % N), 16'hFFFF ^ 16'(k), 1'b0, 4'((k * 3) % N));
        for (int r = 0; r < N; r++) cyc(1'b0, 1'b1, 4'(r), 16'hFFFF, 1'b0, 4'(r));

        // R7: read during write of the same location returns old data
        cur_tag = "R7";
        cyc(1'b1, 1'b0, 4'd5, 16'h1234, 1'b0, 4'd5);
        cyc(1'b0, 1'b0, 4'd0, 16'h0, 1'b0, 4'd5);
        cyc(1'b1, 1'b0, 4'd9, 16'hBEEF, 1'b1, 4'd2);
        cyc(1'b0, 1'b0, 4'd0, 16'h0, 1'b1, 4'd2);

        // R3: shift three new rows in, reading during the shifts
        cur_tag = "R3";
        cyc(1'b1, 1'b1, 4'd0, 16'h0F0F, 1'b0, 4'd0);
        cyc(1'b1, 1'b1, 4'd7, 16'h3C3C, 1'b1, 4'd15);
        cyc(1'b1, 1'b1, 4'd3, 16'h8001, 1'b0, 4'd15);
        for (int r = 0; r < N; r++) cyc(1'b0, 1'b0, 4'd0, 16'h0, 1'b0, 4'(r));
        for (int a = 0; a < N; a++) cyc(1'b0, 1'b0, 4'd0, 16'h0, 1'b1, 4'(a));

        // R6: address and mode change every cycle
        cur_tag = "R6";
        for (int k = 0; k < 32; k++)
            cyc(1'b0, 1'b0, 4'd0, 16'h0, 1'(k), 4'((k * 5 + 3) % N));

        // R1: reset again mid-run
        cur_tag = "R1";
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule